// File: doc/BRIEF.md
# Two-Wire Slave Control Register Bank

This block lets an external bus master program and read back a small bank of eight-bit control registers over a two-wire serial bus, using the common I2C-compatible slave protocol. It answers a single fixed seven-bit device address. The master's first byte after a write address sets an internal register pointer. Each further byte, written or read, uses the register the pointer names and then moves the pointer on by one. The pointer wraps from the last register back to the first, so a master can touch one register or sweep the whole bank in one transfer.

SCL and SDA are oversampled by the block's own clock and passed through synchronizer stages, so the block's logic runs in a single clock domain. SDA is open-drain. The block only pulls it low, through `sda_oe`, and the line is modelled outside the block as a wired-AND. Every register appears in parallel on `reg_q` for the rest of the chip. The block needs only its clock and reset to stay reachable, so it keeps working when the chip's other functions are powered down.

Top module: `i2c_regbank`

## Requirements
- R1: After reset every register holds 0x00, the pointer is 0 and `sda_oe` is 0 (SDA released).
- R2: The block acknowledges (holds `sda_oe`=1 during the ninth SCL high phase) an address byte whose upper seven bits equal DEV_ADDR (0x71, i.e. 0xE2 for a write and 0xE3 for a read, with bit 0 = 1 meaning read). It does not acknowledge any other address, and it ignores the rest of that transfer: no register changes.
- R3: In a write transfer, the first byte after the address is acknowledged and loaded into the pointer. A value of NUM_REGS or more loads 0.
- R4: Each later byte of a write transfer is acknowledged and stored into the register the pointer names, and the pointer then moves up by one.
- R5: After a data byte at the last register (NUM_REGS-1, i.e. 18), the pointer moves to register 0. This holds for both writes and reads.
- R6: A read transfer sends the register at the current pointer, MSB first, one bit per SCL pulse, and the pointer moves up by one for each byte sent. A master ACK (SDA low in the ninth bit) makes the block send the next register. A master NACK ends the transfer with SDA released.
- R7: A STOP or a repeated START returns the block to waiting for an address and releases SDA, while the pointer keeps its value. So writing only an index, then a repeated START and a read, returns the register at that index.
- R8: `sda_oe` changes only while `scl_i` is low.
- R9: `reg_q[8k+7:8k]` carries register k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Resolved level of the serial data line |
| sda_oe | output | 1 | When 1, the block pulls SDA low |
| reg_q | output | NUM_REGS*8 | All registers side by side, register k at bits 8k+7:8k |

## Verification
The bench builds the block with its default parameters: 19 registers, device address 0x71 and two synchronizer stages. With these values every register can be written and read back one at a time in a short run. A 22-byte burst write and a 21-byte burst read both cross the wrap from register 18 to register 0, so the wrap is exercised in each direction. An index above the bank, a foreign device address, and a read that reuses the pointer left by an earlier transfer are each a single transfer in this configuration.

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int         NUM_REGS = 19,
  parameter logic [6:0] DEV_ADDR = 7'h71,
  parameter int         SYNC     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] reg_q
);
  localparam int PW = $clog2(NUM_REGS);

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2, S_REG = 4'd3, S_RACK = 4'd4,
    S_WDAT = 4'd5, S_WACK = 4'd6, S_TX = 4'd7, S_MACK = 4'd8, S_LOAD = 4'd9
  } state_t;

  state_t          st;
  logic [SYNC-1:0] scl_s, sda_s;
  logic            scl_d, sda_d, rw;
  logic [2:0]      cnt;
  logic [6:0]      sh;
  logic [PW-1:0]   ptr;
  logic [7:0]      regs [NUM_REGS];

  wire scl      = scl_s[SYNC-1];
  wire sda      = sda_s[SYNC-1];
  wire rise     = scl & ~scl_d;
  wire fall     = ~scl & scl_d;
  wire start_det = scl & scl_d & sda_d & ~sda;
  wire stop_det  = scl & scl_d & ~sda_d & sda;
  wire last     = (cnt == 3'd7);
  wire [7:0] byte_in = {sh, sda};
  wire [PW-1:0] ptr_nxt = (ptr == PW'(NUM_REGS-1)) ? '0 : ptr + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC-2:0], scl_i};
      sda_s <= {sda_s[SYNC-2:0], sda_i};
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (start_det) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_REG, S_WDAT: if (rise) begin
          sh  <= byte_in[6:0];
          cnt <= cnt + 3'd1;
          if (last) begin
            if (st == S_ADDR) begin
              if (byte_in[7:1] == DEV_ADDR) begin
                st <= S_AACK;
                rw <= byte_in[0];
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_REG) begin
              ptr <= (int'(byte_in) < NUM_REGS) ? byte_in[PW-1:0] : '0;
              st  <= S_RACK;
            end else begin
              regs[ptr] <= byte_in;
              ptr       <= ptr_nxt;
              st        <= S_WACK;
            end
          end
        end
        S_AACK, S_RACK, S_WACK: if (fall) begin
          if (!sda_oe) begin
            sda_oe <= 1'b1;
          end else if (st == S_AACK && rw) begin
            sh     <= regs[ptr][6:0];
            sda_oe <= ~regs[ptr][7];
            ptr    <= ptr_nxt;
            cnt    <= '0;
            st     <= S_TX;
          end else begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= (st == S_AACK) ? S_REG : S_WDAT;
          end
        end
        S_TX: if (fall) begin
          if (last) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_MACK;
          end else begin
            sda_oe <= ~sh[6];
            sh     <= {sh[5:0], 1'b0};
            cnt    <= cnt + 3'd1;
          end
        end
        S_MACK: if (rise) st <= sda ? S_IDLE : S_LOAD;
        S_LOAD: if (fall) begin
          sh     <= regs[ptr][6:0];
          sda_oe <= ~regs[ptr][7];
          ptr    <= ptr_nxt;
          cnt    <= '0;
          st     <= S_TX;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign reg_q[g*8 +: 8] = regs[g];
  end
endmodule

module i2c_regbank_chk #(
  parameter int NUM_REGS = 19
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        scl_i,
  input logic                        sda_oe,
  input logic [NUM_REGS*8-1:0]       reg_q,
  input logic [3:0]                  st,
  input logic [$clog2(NUM_REGS)-1:0] ptr,
  input logic                        stop_det
);
  // R8
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NUM_REGS);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == 4'd0 |-> !sda_oe);

  // R4
  reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_q) |-> $past(st) == 4'd5);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> (st == 4'd0 && !sda_oe));
endmodule

bind i2c_regbank i2c_regbank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .reg_q(reg_q),
  .st(st), .ptr(ptr), .stop_det(stop_det)
);

// File: tb/test_i2c_regbank.sv
module test_i2c_regbank;
  localparam int N = 19;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [N*8-1:0] reg_q;
  wire  sda_line = m_sda & ~sda_oe;

  int checks = 0, errors = 0, viol = 0;
  logic [7:0] model [N];
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_regbank i_i2c_regbank (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_q(reg_q)
  );

  always @(negedge clk) begin
    if (rst_n && scl && sda_oe !== prev_oe) viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic start();
    m_sda = 1'b1; qw(); scl = 1'b1; qw(); m_sda = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic stop();
    m_sda = 1'b0; qw(); scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic wr(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    end
    m_sda = 1'b1; qw(); scl = 1'b1; qw(); ack = sda_oe; qw(); scl = 1'b0; qw();
  endtask

  task automatic rd(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0;
    end
    qw(); m_sda = ~mack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw(); m_sda = 1'b1;
  endtask

  task automatic check_bank(input string tag);
    for (int k = 0; k < N; k++)
      chk(reg_q[k*8 +: 8] === model[k], tag, int'(reg_q[k*8 +: 8]), int'(model[k]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    int p;
    for (int k = 0; k < N; k++) model[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R9: reset state
    chk(sda_oe === 1'b0, "R1 sda released", sda_oe, 0);
    check_bank("R1 R9 reset bank");

    // R2 R3 R4 R9: single-register writes to every index
    for (int k = 0; k < N; k++) begin
      start();
      wr(8'hE2, ack); chk(ack, "R2 write address ack", ack, 1);
      wr(8'(k), ack); chk(ack, "R3 index ack", ack, 1);
      model[k] = 8'((k * 37 + 5) ^ 8'hA5);
      wr(model[k], ack); chk(ack, "R4 data ack", ack, 1);
      stop();
    end
    check_bank("R4 R9 single writes");

    // R6 R7: index write, repeated start, single read of every index
    for (int k = 0; k < N; k++) begin
      start(); wr(8'hE2, ack); wr(8'(k), ack);
      start(); wr(8'hE3, ack); chk(ack, "R2 read address ack", ack, 1);
      rd(1'b0, d); chk(d === model[k], "R6 R7 single read", d, model[k]);
      stop();
      chk(sda_oe === 1'b0, "R6 released after NACK", sda_oe, 0);
    end

    // R4 R5: burst write from 17, 22 bytes, wraps past 18
    start(); wr(8'hE2, ack); wr(8'd17, ack);
    p = 17;
    for (int i = 0; i < 22; i++) begin
      model[p] = 8'(8'hC0 + i * 3);
      wr(model[p], ack); chk(ack, "R4 burst data ack", ack, 1);
      p = (p == N - 1) ? 0 : p + 1;
    end
    stop();
    check_bank("R5 burst write wrap");

    // R5 R6: burst read from 16, 21 bytes, wraps past 18
    start(); wr(8'hE2, ack); wr(8'd16, ack);
    start(); wr(8'hE3, ack);
    p = 16;
    for (int i = 0; i < 21; i++) begin
      rd(i != 20, d);
      chk(d === model[p], "R5 R6 burst read", d, model[p]);
      p = (p == N - 1) ? 0 : p + 1;
    end
    stop();

    // R7: pointer retained across transfers (now 18)
    start(); wr(8'hE3, ack);
    rd(1'b0, d); chk(d === model[p], "R7 pointer retained", d, model[p]);
    stop();

    // R2: foreign address not acknowledged, rest ignored
    start();
    wr(8'hA0, ack); chk(!ack, "R2 foreign address nack", ack, 0);
    wr(8'd3, ack);  chk(!ack, "R2 ignored byte nack", ack, 0);
    wr(8'h5A, ack); chk(!ack, "R2 ignored byte nack", ack, 0);
    stop();
    check_bank("R2 bank unchanged");

    // R3: out-of-range index loads 0
    start(); wr(8'hE2, ack); wr(8'd25, ack);
    chk(ack, "R3 out-of-range index ack", ack, 1);
    model[0] = 8'h3C; model[1] = 8'hD2;
    wr(8'h3C, ack); wr(8'hD2, ack);
    stop();
    check_bank("R3 out-of-range index");

    // R8: no change of sda_oe while SCL high
    chk(viol == 0, "R8 sda_oe change with SCL high", viol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule